// File: doc/BRIEF.md
# Bit-Addressed Field Access Engine

This block lets a client read or write a bit field of 1 to 32 bits that starts at any bit position in a memory built from 32-bit words. Two field types are configured on plain pins, each with its own width code and its own extension flag. A request names one of the two types, or asks for a byte, and carries a bit address and, for a write, the value to store. For a read, the engine fetches the one or two words that cover the field. It then shifts, masks and extends the field into a 32-bit result. For a write, it fetches the covering words, merges the new field bits into them and writes them back. All other bits keep their values.

Requests enter on a valid/ready handshake. `req_ready` is high only while the engine is idle, so a request that is held waiting keeps its fields stable until the edge where both signals are high. The memory command port is also valid/ready: while `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command fields are held. A read command is answered by exactly one `mem_rsp_valid` beat, at any later cycle, and the engine accepts that beat at once. Completion is a one-cycle `done` pulse. A read result sits on `rd_data` during that pulse and stays there until the next request is accepted.

Top module: `fld_access`

## Requirements
- R1: The field select `req_sel` (0 or 1) picks the width code and extension flag of that field type, captured when the request is accepted. A width code of 0 means 32 bits, and codes 1 to 31 mean that many bits.
- R2: A read returns, in `rd_data` bits [size-1:0], the memory bits starting at the bit address, with bit address bit 0 of the field in `rd_data` bit 0.
- R3: When the extension flag is 1, `rd_data` bits above the field are copies of the field's top bit. When the flag is 0, they are zero.
- R4: When bit offset (bit address bits [4:0]) plus field size exceeds 32, the field spans two words. The engine reads word W and then word W+1, and the low part of the field comes from word W.
- R5: The word address on `mem_cmd_addr` is the bit address shifted right by 5. A read issues read commands only (`mem_cmd_we`=0) for the covering words, in ascending order.
- R6: A write first reads every covering word and then writes each back (`mem_cmd_we`=1), with only the field bits replaced by `req_wdata` bits [size-1:0]. Every bit outside the field is unchanged.
- R7: A spanning write stores word W before word W+1. A non-spanning write stores only word W.
- R8: With `req_byte`=1 the field is 8 bits at any bit alignment, including across a word boundary. The extension flag still comes from the selected field type.
- R9: `req_ready` is 1 only when the engine is idle. No request is taken while an access is in progress.
- R10: `done` is high for exactly one cycle. For a read it follows the cycle that takes the final response; for a write it follows the cycle that takes the final write command. No memory command comes between `done` and the next accepted request.
- R11: While `mem_cmd_valid`=1 and `mem_cmd_ready`=0, the command stays valid and its address, direction and write data do not change.
- R12: During and right after reset, `req_ready`=1, `done`=0 and `mem_cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs0 | input | 5 | Width code of field type 0 (0 means 32) |
| fe0 | input | 1 | Field type 0: 1 sign-extends, 0 zero-extends |
| fs1 | input | 5 | Width code of field type 1 (0 means 32) |
| fe1 | input | 1 | Field type 1: 1 sign-extends, 0 zero-extends |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | 1 | Field type select |
| req_byte | input | 1 | Force an 8-bit field |
| req_addr | input | ADDR_W | Bit address of field bit 0 |
| req_wdata | input | 32 | Write value, low bits used |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Extended read result, valid with done |
| mem_cmd_valid | output | 1 | Memory command offered |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_we | output | 1 | 1 write, 0 read |
| mem_cmd_addr | output | ADDR_W-5 | Word address |
| mem_cmd_wdata | output | 32 | Merged word for a write |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Read word |

## Verification
The first memory command is offered in the cycle after a request is accepted. Each later command is offered in the cycle after the previous command was taken or the previous response arrived. `done` with its read result appears one cycle after the last response or the last write is taken. The bench computes the expected command list and result when it issues a request, and then compares on every cycle. It checks each command at the edge where it is taken, the held command during every stalled cycle, `req_ready` during every busy cycle, and `rd_data` in the cycle of `done`. Memory responses and the ready pattern are driven half a cycle away from the sampling edge, and some runs stall the command port so that held commands are exercised.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  localparam int unsigned LW   = 32;
  localparam int unsigned OFFW = 5;
  localparam int unsigned SZW  = 6;

  typedef struct packed {
    logic [SZW-1:0] size;
    logic           sext;
  } fld_attr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_WT0,
    ST_RD1,
    ST_WT1,
    ST_WR0,
    ST_WR1
  } seq_state_t;

  // ones in bit positions below size
  function automatic logic [LW-1:0] low_mask(input logic [SZW-1:0] size);
    logic [LW-1:0] m;
    for (int i = 0; i < int'(LW); i++) begin
      m[i] = (i < int'(size));
    end
    return m;
  endfunction
endpackage

// File: rtl/fld_attr_sel.sv
`timescale 1ns/1ps
module fld_attr_sel import fld_pkg::*; #(
  parameter int NF  = 2,
  parameter int SCW = 5,
  localparam int SELW = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [NF-1:0][SCW-1:0] size_code,
  input  logic [NF-1:0]          ext_en,
  input  logic [SELW-1:0]        sel,
  input  logic                   byte_mode,
  output fld_attr_t              attr
);
  logic [NF-1:0][SZW-1:0] dec_size;

  for (genvar f = 0; f < NF; f++) begin : g_fld
    assign dec_size[f] = (size_code[f] == '0) ? SZW'(LW) : SZW'(size_code[f]);
  end

  always_comb begin
    attr.size = dec_size[0];
    attr.sext = ext_en[0];
    for (int f = 1; f < NF; f++) begin
      if (sel == SELW'(f)) begin
        attr.size = dec_size[f];
        attr.sext = ext_en[f];
      end
    end
    if (byte_mode) begin
      attr.size = SZW'(8);
    end
  end
endmodule

// File: rtl/fld_extract.sv
`timescale 1ns/1ps
module fld_extract import fld_pkg::*; (
  input  logic [LW-1:0]   word_lo,
  input  logic [LW-1:0]   word_hi,
  input  logic [OFFW-1:0] off,
  input  fld_attr_t       attr,
  output logic [LW-1:0]   result
);
  logic [2*LW-1:0] cat;
  logic [LW-1:0]   m;
  logic [LW-1:0]   top_bit;
  logic [LW-1:0]   raw;
  logic            fill;

  always_comb begin
    cat     = {word_hi, word_lo};
    m       = low_mask(attr.size);
    top_bit = m & ~(m >> 1);
    raw     = LW'(cat >> off) & m;
    fill    = attr.sext && (|(raw & top_bit));
    result  = raw | (fill ? ~m : '0);
  end
endmodule

// File: rtl/fld_insert.sv
`timescale 1ns/1ps
module fld_insert import fld_pkg::*; (
  input  logic [LW-1:0]   word_lo,
  input  logic [LW-1:0]   word_hi,
  input  logic [OFFW-1:0] off,
  input  fld_attr_t       attr,
  input  logic [LW-1:0]   wdata,
  output logic [LW-1:0]   new_lo,
  output logic [LW-1:0]   new_hi
);
  logic [LW-1:0]   m;
  logic [2*LW-1:0] place_mask;
  logic [2*LW-1:0] place_data;
  logic [2*LW-1:0] merged;

  always_comb begin
    m          = low_mask(attr.size);
    place_mask = {{LW{1'b0}}, m} << off;
    place_data = {{LW{1'b0}}, wdata & m} << off;
    merged     = ({word_hi, word_lo} & ~place_mask) | place_data;
    new_lo     = merged[LW-1:0];
    new_hi     = merged[2*LW-1:LW];
  end
endmodule

// File: rtl/fld_seq.sv
`timescale 1ns/1ps
module fld_seq import fld_pkg::*; #(
  parameter int WAW = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [WAW-1:0]  req_waddr,
  input  logic [OFFW-1:0] req_off,
  input  fld_attr_t       req_attr,
  input  logic [LW-1:0]   req_wdata,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic            cmd_we,
  output logic [WAW-1:0]  cmd_addr,
  output logic [LW-1:0]   cmd_wdata,
  input  logic            rsp_valid,
  input  logic [LW-1:0]   rsp_data,
  input  logic [LW-1:0]   new_lo,
  input  logic [LW-1:0]   new_hi,
  output logic            done,
  output logic [OFFW-1:0] cur_off,
  output fld_attr_t       cur_attr,
  output logic [LW-1:0]   cur_wdata,
  output logic [LW-1:0]   word_lo,
  output logic [LW-1:0]   word_hi
);
  seq_state_t     state;
  logic [WAW-1:0] waddr;
  logic           wr;
  logic           span;

  assign span = ({2'b00, cur_off} + {1'b0, cur_attr.size}) > 7'd32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      waddr     <= '0;
      wr        <= 1'b0;
      cur_off   <= '0;
      cur_attr  <= '0;
      cur_wdata <= '0;
      word_lo   <= '0;
      word_hi   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            waddr     <= req_waddr;
            wr        <= req_write;
            cur_off   <= req_off;
            cur_attr  <= req_attr;
            cur_wdata <= req_wdata;
            state     <= ST_RD0;
          end
        end
        ST_RD0: if (cmd_ready) state <= ST_WT0;
        ST_WT0: begin
          if (rsp_valid) begin
            word_lo <= rsp_data;
            if (span) begin
              state <= ST_RD1;
            end else if (wr) begin
              state <= ST_WR0;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_RD1: if (cmd_ready) state <= ST_WT1;
        ST_WT1: begin
          if (rsp_valid) begin
            word_hi <= rsp_data;
            if (wr) begin
              state <= ST_WR0;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_WR0: begin
          if (cmd_ready) begin
            if (span) begin
              state <= ST_WR1;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_WR1: begin
          if (cmd_ready) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    cmd_valid = (state == ST_RD0) || (state == ST_RD1) ||
                (state == ST_WR0) || (state == ST_WR1);
    cmd_we    = (state == ST_WR0) || (state == ST_WR1);
    cmd_addr  = ((state == ST_RD1) || (state == ST_WR1)) ? (waddr + WAW'(1)) : waddr;
    cmd_wdata = (state == ST_WR1) ? new_hi : new_lo;
  end
endmodule

// File: rtl/fld_access.sv
`timescale 1ns/1ps
module fld_access import fld_pkg::*; #(
  parameter int ADDR_W = 32,
  localparam int WAW = ADDR_W - OFFW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFFW-1:0]   fs0,
  input  logic              fe0,
  input  logic [OFFW-1:0]   fs1,
  input  logic              fe1,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic              req_byte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LW-1:0]     req_wdata,
  output logic              done,
  output logic [LW-1:0]     rd_data,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_we,
  output logic [WAW-1:0]    mem_cmd_addr,
  output logic [LW-1:0]     mem_cmd_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LW-1:0]     mem_rsp_data
);
  fld_attr_t       sel_attr;
  fld_attr_t       cur_attr;
  logic [OFFW-1:0] cur_off;
  logic [LW-1:0]   cur_wdata;
  logic [LW-1:0]   word_lo;
  logic [LW-1:0]   word_hi;
  logic [LW-1:0]   new_lo;
  logic [LW-1:0]   new_hi;

  fld_attr_sel #(.NF(2), .SCW(OFFW)) u_attr (
    .size_code ({fs1, fs0}),
    .ext_en    ({fe1, fe0}),
    .sel       (req_sel),
    .byte_mode (req_byte),
    .attr      (sel_attr)
  );

  fld_seq #(.WAW(WAW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_waddr (req_addr[ADDR_W-1:OFFW]),
    .req_off   (req_addr[OFFW-1:0]),
    .req_attr  (sel_attr),
    .req_wdata (req_wdata),
    .cmd_valid (mem_cmd_valid),
    .cmd_ready (mem_cmd_ready),
    .cmd_we    (mem_cmd_we),
    .cmd_addr  (mem_cmd_addr),
    .cmd_wdata (mem_cmd_wdata),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .new_lo    (new_lo),
    .new_hi    (new_hi),
    .done      (done),
    .cur_off   (cur_off),
    .cur_attr  (cur_attr),
    .cur_wdata (cur_wdata),
    .word_lo   (word_lo),
    .word_hi   (word_hi)
  );

  fld_extract u_ext (
    .word_lo (word_lo),
    .word_hi (word_hi),
    .off     (cur_off),
    .attr    (cur_attr),
    .result  (rd_data)
  );

  fld_insert u_ins (
    .word_lo (word_lo),
    .word_hi (word_hi),
    .off     (cur_off),
    .attr    (cur_attr),
    .wdata   (cur_wdata),
    .new_lo  (new_lo),
    .new_hi  (new_hi)
  );
endmodule

// File: rtl/fld_access_chk.sv
`timescale 1ns/1ps
module fld_access_chk #(
  parameter int ADDR_W = 32,
  localparam int WAW = ADDR_W - 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           done,
  input logic           mem_cmd_valid,
  input logic           mem_cmd_ready,
  input logic           mem_cmd_we,
  input logic [WAW-1:0] mem_cmd_addr,
  input logic [31:0]    mem_cmd_wdata
);
  p_idle_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_cmd_valid);

  p_take_then_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_we) && $stable(mem_cmd_wdata)));
endmodule

bind fld_access fld_access_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_fld_access.sv
`timescale 1ns/1ps
module test_fld_access;
  localparam int ADDR_W = 32;
  localparam int WAW    = ADDR_W - 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [4:0]        fs0, fs1;
  logic              fe0, fe1;
  logic              req_valid, req_write, req_sel, req_byte;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              done;
  logic [31:0]       rd_data;
  logic              mem_cmd_valid, mem_cmd_we;
  logic              mem_cmd_ready = 1'b0;
  logic [WAW-1:0]    mem_cmd_addr;
  logic [31:0]       mem_cmd_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;

  fld_access #(.ADDR_W(ADDR_W)) i_fld_access (
    .clk(clk), .rst_n(rst_n), .fs0(fs0), .fe0(fe0), .fs1(fs1), .fe1(fe1),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_we(mem_cmd_we), .mem_cmd_addr(mem_cmd_addr),
    .mem_cmd_wdata(mem_cmd_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int          errors = 0;
  int          checks = 0;
  logic [31:0] mem [int];
  bit          exp_we [$];
  int          exp_addr [$];
  logic [31:0] exp_wd [$];
  logic [31:0] exp_rd;
  bit          exp_is_read;
  string       exp_tag;
  bit          busy = 0, accepted = 0, stall = 0;
  int          cyc = 0;
  bit          rsp_pend = 0;
  logic [31:0] rsp_pend_data;
  bit          hold_prev = 0;
  logic [WAW-1:0] hold_addr;
  logic [31:0]    hold_wd;
  logic           hold_we;
  int unsigned lcg = 32'h1234_5678;

  function automatic logic [31:0] mem_get(int a);
    if (mem.exists(a)) return mem[a];
    return logic'(1'b0) ? 32'h0 : (32'(a) * 32'h9E37_79B1) ^ 32'h3C6E_F372;
  endfunction

  task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, expv);
    end
  endtask

  task automatic do_op(string tag, bit wr, bit sel, bit byt, int unsigned baddr, logic [31:0] wd);
    int code, sz, off, wa;
    bit sx, span;
    logic [63:0] cat;
    code = sel ? int'(fs1) : int'(fs0);
    sz   = byt ? 8 : ((code == 0) ? 32 : code);
    sx   = sel ? fe1 : fe0;
    wa   = int'(baddr >> 5);
    off  = int'(baddr & 31);
    span = (off + sz) > 32;
    cat  = {mem_get(wa + 1), mem_get(wa)};
    exp_we.push_back(1'b0); exp_addr.push_back(wa); exp_wd.push_back('0);
    if (span) begin
      exp_we.push_back(1'b0); exp_addr.push_back(wa + 1); exp_wd.push_back('0);
    end
    if (wr) begin
      for (int i = 0; i < sz; i++) cat[off + i] = wd[i];
      exp_we.push_back(1'b1); exp_addr.push_back(wa); exp_wd.push_back(cat[31:0]);
      if (span) begin
        exp_we.push_back(1'b1); exp_addr.push_back(wa + 1); exp_wd.push_back(cat[63:32]);
      end
      exp_is_read = 0;
    end else begin
      for (int i = 0; i < 32; i++)
        exp_rd[i] = (i < sz) ? cat[off + i] : (sx ? cat[off + sz - 1] : 1'b0);
      exp_is_read = 1;
    end
    exp_tag = tag;
    busy = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_byte = byt;
    req_addr = baddr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    accepted = 1;
    @(negedge clk);
    req_valid = 1'b0;
    wait (!busy);
  endtask

  // memory model and per-cycle comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rsp_valid = 1'b0;
      mem_cmd_ready = 1'b0;
      rsp_pend = 0;
      hold_prev = 0;
    end else begin
      mem_rsp_valid = rsp_pend;
      mem_rsp_data  = rsp_pend ? rsp_pend_data : 32'hDEAD_BEEF;
      rsp_pend = 0;
      mem_cmd_ready = stall ? ((cyc % 3) == 2) : 1'b1;
      cyc++;
      #1;
      if (hold_prev)
        check(mem_cmd_valid && mem_cmd_addr == hold_addr && mem_cmd_we == hold_we &&
              mem_cmd_wdata == hold_wd, "R11 held command", mem_cmd_wdata, hold_wd);
      hold_prev = mem_cmd_valid && !mem_cmd_ready;
      hold_addr = mem_cmd_addr; hold_we = mem_cmd_we; hold_wd = mem_cmd_wdata;
      if (mem_cmd_valid && mem_cmd_ready) begin
        if (exp_we.size() == 0) begin
          check(0, "R10 command with none expected", 32'(mem_cmd_addr), 32'hFFFF_FFFF);
        end else begin
          bit e_we; int e_a; logic [31:0] e_d;
          e_we = exp_we.pop_front(); e_a = exp_addr.pop_front(); e_d = exp_wd.pop_front();
          check(mem_cmd_we == e_we && int'(mem_cmd_addr) == e_a,
                {exp_tag, " R5 command address and order"}, 32'(mem_cmd_addr), 32'(e_a));
          if (e_we) begin
            check(mem_cmd_wdata == e_d, {exp_tag, " R6 merged word"}, mem_cmd_wdata, e_d);
          end else begin
            rsp_pend = 1;
            rsp_pend_data = mem_get(int'(mem_cmd_addr));
          end
        end
        if (mem_cmd_we) mem[int'(mem_cmd_addr)] = mem_cmd_wdata;
      end
      if (done) begin
        check(busy && accepted && exp_we.size() == 0, "R10 done after final access",
              32'(exp_we.size()), 32'h0);
        if (exp_is_read) check(rd_data == exp_rd, {exp_tag, " read result"}, rd_data, exp_rd);
        busy = 0; accepted = 0;
      end else if (accepted) begin
        check(!req_ready, "R9 ready low while busy", 32'(req_ready), 32'h0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_sel = 0; req_byte = 0; req_addr = '0; req_wdata = '0;
    fs0 = 5'd5; fe0 = 0; fs1 = 5'd12; fe1 = 1;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !mem_cmd_valid, "R12 reset state",
          {29'd0, req_ready, done, mem_cmd_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !mem_cmd_valid, "R12 after reset",
          {29'd0, req_ready, done, mem_cmd_valid}, 32'h4);

    mem[0] = 32'hF0F0_A5C3; mem[1] = 32'h1357_9BDF; mem[2] = 32'h8000_0001;
    do_op("R2 R1 field0 unsigned", 0, 0, 0, 3, 0);
    fe0 = 1;
    do_op("R3 field0 signed", 0, 0, 0, 5, 0);
    do_op("R4 R1 field1 spanning signed", 0, 1, 0, 25, 0);
    fs0 = 5'd0; fe0 = 0;
    do_op("R1 code zero is 32 bits", 0, 0, 0, 32, 0);
    do_op("R4 32-bit spanning", 0, 0, 0, 17, 0);
    fs1 = 5'd1; fe1 = 1;
    do_op("R3 one bit at top", 0, 1, 0, 31, 0);
    do_op("R8 byte spanning", 0, 1, 1, 60, 0);
    fe1 = 0;
    do_op("R8 byte unsigned", 0, 1, 1, 9, 0);
    fs0 = 5'd7;
    do_op("R6 write inside word", 1, 0, 0, 42, 32'hFFFF_FF55);
    do_op("R6 readback", 0, 0, 0, 42, 0);
    fs1 = 5'd20;
    do_op("R7 spanning write", 1, 1, 0, 86, 32'h000A_BCDE);
    do_op("R7 readback", 0, 1, 0, 86, 0);
    fs0 = 5'd0;
    do_op("R7 32-bit write", 1, 0, 0, 137, 32'hCAFE_F00D);
    do_op("R7 32-bit readback", 0, 0, 0, 137, 0);
    do_op("R8 byte write", 1, 1, 1, 188, 32'h0000_00A7);
    do_op("R8 byte readback", 0, 1, 1, 188, 0);
    fs1 = 5'd31; fe1 = 1;
    do_op("R3 size 31 signed", 0, 1, 0, 1, 0);

    for (int k = 0; k < 60; k++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      stall = lcg[30];
      fs0 = lcg[4:0]; fe0 = lcg[5]; fs1 = lcg[10:6]; fe1 = lcg[11];
      do_op(lcg[12] ? "R6 mixed write" : "R2 mixed read", lcg[12], lcg[13],
            lcg[14] & lcg[15], {23'd0, lcg[24:16]}, {lcg[7:0], lcg[31:8]});
    end
    stall = 0;

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule